// File: doc/BRIEF.md
# Vendor-Specific Control Word Scheduler

This block follows where the current basic frame sits inside a 256-frame hyperframe and decides, from that position and a pointer-P boundary value, which control-word slots belong to the vendor-specific subchannels. For each such slot it raises a per-byte-lane ready strobe toward a user source. The source answers, a fixed write latency later, with a 32-bit word and per-lane valid bits. The block then emits the accepted bytes, with a per-lane write enable, as the content of that slot's control word.

The hyperframe position advances on a basic-frame strobe. A hyperframe-start strobe, given together with a basic-frame strobe, reloads the position to zero. After reset the block stays idle, with no ready and no writes, until the first hyperframe start arrives. Only the lanes set in a lane-mask parameter are ever offered. The default is the single upper lane, as used at the lowest line rate.

Top module: `vs_cw_sched`

## Requirements
- R1: Once armed, every cycle with `bf_tick` high and `hf_sync` low advances `bf_index` by one at the clock edge, wrapping from 255 to 0.
- R2: A cycle with `bf_tick` and `hf_sync` both high loads `bf_index` with 0 at the clock edge, from any position.
- R3: `subch_index` always equals `bf_index` modulo 64, i.e. its low six bits.
- R4: In the cycle right after a basic-frame edge, `vs_ready` equals the lane mask (default 4'b1000: only byte lane 3, bits [31:24]) when `subch_index` lies in 16 up to `ptr_p` minus 1. In every other cycle it is zero.
- R5: When `ptr_p` is below 17 or above 63, `vs_ready` stays zero in every cycle.
- R6: With write latency L (default 1), the word on `vs_data` in the cycle L cycles after a ready cycle is captured. In the following cycle `cw_be` equals that ready mask for exactly one cycle.
- R7: In a captured slot, a lane whose `vs_valid` bit is low is emitted as 8'h00. A lane whose bit is high carries the matching byte of `vs_data`.
- R8: In cycles without a capture, `cw_be` is zero and `cw_data` keeps its previous value.
- R9: After reset `bf_index` is 0 and `vs_ready`, `cw_be` and `cw_data` are zero. Basic-frame strobes before the first hyperframe start neither advance the index nor raise ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bf_tick | input | 1 | Basic-frame strobe, one cycle per basic frame |
| hf_sync | input | 1 | Hyperframe start, effective only together with `bf_tick` |
| ptr_p | input | 7 | Pointer-P; exclusive upper bound of the vendor-specific subchannels |
| vs_valid | input | 4 | Per-lane valid for `vs_data` |
| vs_data | input | 32 | User vendor-specific word, lane i at bits [8i+7:8i] |
| vs_ready | output | 4 | Per-lane ready strobe for the upcoming slot |
| bf_index | output | 8 | Basic-frame index inside the hyperframe |
| subch_index | output | 6 | Control-word subchannel index |
| cw_data | output | 32 | Bytes inserted into the control word |
| cw_be | output | 4 | Per-lane write enable for `cw_data` |

## Verification
A wrong hyperframe position shows at the ports within one cycle, because `bf_index` and `subch_index` are compared against the bench's own frame count after every clock edge. A ready decode error, whether at the subchannel 16 edge, at pointer-P, or in the invalid pointer ranges, appears on `vs_ready` in the cycle right after the affected basic-frame edge. A latency slip or a lost or zero-fill error appears on `cw_be` and `cw_data` L+1 cycles after that ready cycle. Slot totals counted over a whole hyperframe catch errors that repeat once per hyperframe.

// File: rtl/vs_sched_pkg.sv
package vs_sched_pkg;

  localparam int unsigned VS_FIRST_SC = 16;
  localparam int unsigned VS_PTR_MIN  = 17;
  localparam int unsigned VS_PTR_MAX  = 63;

  // true when subchannel sc carries vendor-specific data under pointer p
  function automatic bit slot_is_vs(int unsigned sc, int unsigned p);
    bit p_ok;
    p_ok = (p >= VS_PTR_MIN) && (p <= VS_PTR_MAX);
    return p_ok && (sc >= VS_FIRST_SC) && (sc < p);
  endfunction

  // a lane byte after the valid gate
  function automatic logic [7:0] gate_byte(logic [7:0] b, logic v);
    return v ? b : 8'h00;
  endfunction

endpackage

// File: rtl/vs_hf_tracker.sv
module vs_hf_tracker #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bf_tick,
  input  logic             hf_sync,
  output logic [IDX_W-1:0] bf_index,
  output logic             armed,
  output logic             frame_start
);

  logic start_hf;
  logic step_bf;

  assign start_hf = bf_tick && hf_sync;
  assign step_bf  = bf_tick && !hf_sync && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bf_index    <= '0;
      armed       <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= start_hf || step_bf;
      if (start_hf) begin
        bf_index <= '0;
        armed    <= 1'b1;
      end else if (step_bf) begin
        bf_index <= bf_index + 1'b1;
      end
    end
  end

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_bf && (&bf_index)) |=> (bf_index == '0));

  a_r2_sync_loads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start_hf |=> (bf_index == '0) && armed);

endmodule

// File: rtl/vs_slot_window.sv
module vs_slot_window
  import vs_sched_pkg::*;
#(
  parameter int               SC_W      = 6,
  parameter int               PTR_W     = 7,
  parameter int               LANES     = 4,
  parameter logic [LANES-1:0] LANE_MASK = 4'b1000
) (
  input  logic              frame_start,
  input  logic              armed,
  input  logic [SC_W-1:0]   subch,
  input  logic [PTR_W-1:0]  ptr_p,
  output logic [LANES-1:0]  ready
);

  logic in_window;

  always_comb begin
    in_window = slot_is_vs(int'(subch), int'(ptr_p));
    ready     = (frame_start && armed && in_window) ? LANE_MASK : '0;
  end

endmodule

// File: rtl/vs_insert_pipe.sv
module vs_insert_pipe
  import vs_sched_pkg::*;
#(
  parameter int               LANES     = 4,
  parameter int               LAT       = 1,
  parameter logic [LANES-1:0] LANE_MASK = 4'b1000,
  localparam int              DW        = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  ready,
  input  logic [LANES-1:0]  valid,
  input  logic [DW-1:0]     data,
  output logic [LANES-1:0]  cap_mask,
  output logic [DW-1:0]     cw_data,
  output logic [LANES-1:0]  cw_be
);

  logic [DW-1:0] gated;

  generate
    if (LAT == 0) begin : g_nolat
      assign cap_mask = ready;
    end else begin : g_lat
      logic [LANES-1:0] dly [LAT];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < LAT; i++) dly[i] <= '0;
        end else begin
          dly[0] <= ready;
          for (int i = 1; i < LAT; i++) dly[i] <= dly[i-1];
        end
      end
      assign cap_mask = dly[LAT-1];
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign gated[ln*8 +: 8] = gate_byte(data[ln*8 +: 8], valid[ln]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cw_data[ln*8 +: 8] <= 8'h00;
          cw_be[ln]          <= 1'b0;
        end else begin
          cw_be[ln] <= cap_mask[ln];
          if (cap_mask[ln]) cw_data[ln*8 +: 8] <= gated[ln*8 +: 8];
        end
      end
    end
  endgenerate

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mask == '0) |=> (cw_be == '0) && $stable(cw_data));

  a_r6_lanes_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_be & ~LANE_MASK) == '0);

endmodule

// File: rtl/vs_cw_sched.sv
module vs_cw_sched #(
  parameter int          IDX_W     = 8,
  parameter int          SC_W      = 6,
  parameter int          PTR_W     = 7,
  parameter int          LANES     = 4,
  parameter int          LAT       = 1,
  parameter logic [3:0]  LANE_MASK = 4'b1000,
  localparam int         DW        = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bf_tick,
  input  logic              hf_sync,
  input  logic [PTR_W-1:0]  ptr_p,
  input  logic [LANES-1:0]  vs_valid,
  input  logic [DW-1:0]     vs_data,
  output logic [LANES-1:0]  vs_ready,
  output logic [IDX_W-1:0]  bf_index,
  output logic [SC_W-1:0]   subch_index,
  output logic [DW-1:0]     cw_data,
  output logic [LANES-1:0]  cw_be
);

  logic             armed;
  logic             frame_start;
  logic [LANES-1:0] cap_mask;

  vs_hf_tracker #(.IDX_W(IDX_W)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bf_tick     (bf_tick),
    .hf_sync     (hf_sync),
    .bf_index    (bf_index),
    .armed       (armed),
    .frame_start (frame_start)
  );

  assign subch_index = bf_index[SC_W-1:0];

  vs_slot_window #(
    .SC_W      (SC_W),
    .PTR_W     (PTR_W),
    .LANES     (LANES),
    .LANE_MASK (LANE_MASK[LANES-1:0])
  ) u_win (
    .frame_start (frame_start),
    .armed       (armed),
    .subch       (subch_index),
    .ptr_p       (ptr_p),
    .ready       (vs_ready)
  );

  vs_insert_pipe #(
    .LANES     (LANES),
    .LAT       (LAT),
    .LANE_MASK (LANE_MASK[LANES-1:0])
  ) u_ins (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (vs_ready),
    .valid    (vs_valid),
    .data     (vs_data),
    .cap_mask (cap_mask),
    .cw_data  (cw_data),
    .cw_be    (cw_be)
  );

  a_r9_idle_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (vs_ready == '0) && (cap_mask == '0));

  a_r4_ready_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_ready != '0) |-> $past(bf_tick));

  a_r5_bad_ptr_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr_p < 7'd17) || (ptr_p > 7'd63)) |-> (vs_ready == '0));

endmodule

// File: tb/vs_cw_sched_tb.sv
module vs_cw_sched_tb;

  localparam int L = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bf_tick;
  logic        hf_sync;
  logic [6:0]  ptr_p;
  logic [3:0]  vs_valid;
  logic [31:0] vs_data;
  logic [3:0]  vs_ready;
  logic [7:0]  bf_index;
  logic [5:0]  subch_index;
  logic [31:0] cw_data;
  logic [3:0]  cw_be;

  always #2.5 clk = ~clk;

  vs_cw_sched u_dut (
    .clk(clk), .rst_n(rst_n), .bf_tick(bf_tick), .hf_sync(hf_sync),
    .ptr_p(ptr_p), .vs_valid(vs_valid), .vs_data(vs_data),
    .vs_ready(vs_ready), .bf_index(bf_index), .subch_index(subch_index),
    .cw_data(cw_data), .cw_be(cw_be)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_idx = 0;
  bit m_armed = 0;
  bit m_newf = 0;
  int m_be = 0;
  logic [31:0] m_data = 0;
  int rdy_hist[$];
  int writes = 0;
  int readies = 0;

  function automatic int exp_ready(int p);
    int sc;
    sc = m_idx % 64;
    if (m_newf && m_armed && p >= 17 && p <= 63 && sc >= 16 && sc < p) return 8;
    return 0;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int r;
    int cap;
    r = exp_ready(int'(ptr_p));
    rdy_hist.push_back(r);
    cap = (rdy_hist.size() > L) ? rdy_hist[rdy_hist.size()-1-L] : 0;
    if (rdy_hist.size() > 8) void'(rdy_hist.pop_front());
    m_be = cap;
    for (int ln = 0; ln < 4; ln++)
      if (cap[ln]) m_data[ln*8 +: 8] = vs_valid[ln] ? vs_data[ln*8 +: 8] : 8'h00;
    if (bf_tick && hf_sync) begin
      m_idx = 0; m_armed = 1; m_newf = 1;
    end else if (bf_tick && m_armed) begin
      m_idx = (m_idx + 1) % 256; m_newf = 1;
    end else begin
      m_newf = 0;
    end
  endtask

  task automatic step(bit tick, bit sync);
    bf_tick  = tick;
    hf_sync  = sync;
    vs_data  = $urandom;
    vs_valid = 4'($urandom);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1 R2 bf_index", bf_index, m_idx);
    chk("R3 subch_index", subch_index, m_idx % 64);
    chk("R4 R5 vs_ready", vs_ready, exp_ready(int'(ptr_p)));
    chk("R6 R8 cw_be", cw_be, m_be);
    chk("R7 R8 cw_data", cw_data, m_data);
    if (cw_be != 0) writes++;
    if (vs_ready != 0) readies++;
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      step(1, 0);
      step(0, 0);
    end
  endtask

  initial begin
    rst_n = 0; bf_tick = 0; hf_sync = 0; ptr_p = 7'd60;
    vs_valid = 0; vs_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R9: reset state
    chk("R9 reset bf_index", bf_index, 0);
    chk("R9 reset vs_ready", vs_ready, 0);
    chk("R9 reset cw_be", cw_be, 0);
    chk("R9 reset cw_data", cw_data, 0);
    // R9: ticks before the first hyperframe start do nothing
    readies = 0;
    frames(5);
    chk("R9 no advance before sync", bf_index, 0);
    chk("R9 no ready before sync", readies, 0);
    // R1 R4 R6 R7: one full hyperframe with pointer 60
    writes = 0;
    step(1, 1); step(0, 0);
    frames(255);
    repeat (4) step(0, 0);
    chk("R6 writes per hyperframe ptr=60", writes, 176);
    // R1: wrap from 255 to 0
    chk("R1 index before wrap", bf_index, 255);
    step(1, 0);
    chk("R1 wrap to zero", bf_index, 0);
    step(0, 0);
    // R4: boundary pointer 17, only subchannel 16 qualifies
    ptr_p = 7'd17;
    writes = 0;
    frames(64);
    repeat (4) step(0, 0);
    chk("R4 ptr=17 single slot", writes, 1);
    // R5: pointer below 17 and above 63
    ptr_p = 7'd16; readies = 0; frames(64);
    chk("R5 ptr=16 no ready", readies, 0);
    ptr_p = 7'd100; readies = 0; frames(64);
    chk("R5 ptr=100 no ready", readies, 0);
    // R2: resync in mid hyperframe
    ptr_p = 7'd40;
    frames(20);
    step(1, 1);
    chk("R2 resync to zero", bf_index, 0);
    step(0, 0);
    // R8 R7: back-to-back ticks across the window
    for (int i = 0; i < 80; i++) step(1, 0);
    repeat (4) step(0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule